// File: doc/BRIEF.md
# Timer Input Capture Channel

This block timestamps activity on one asynchronous input pin. It brings the pin into the system clock domain with a two-stage synchronizer and an edge-detect register. It then picks out the edges that count under the selected capture mode. On each qualifying edge it stores the value of one of two free-running 16-bit timers into a four-entry capture queue. The timers are produced elsewhere. The block only samples them.

Software-side logic sets the capture mode, the timer choice and the number of captures that make up one interrupt. Modes cover falling edges, rising edges, both edges, and every 4th or every 16th rising edge. Captures are read oldest first through a pop strobe. A sticky interrupt flag goes high a fixed two cycles after the capture that completes the programmed count, and stays high until a clear strobe. If the queue is full, new captures are dropped and a sticky overflow bit is set.

Top module: `ic_capture_channel`

## Requirements
- R1: After reset, `fifo_nempty`, `irq_flag` and `fifo_ovf` are all 0.
- R2: With `cap_mode` = 3'b010, each falling edge of `cap_pin` stores one capture. The stored value is the selected timer value that is present two clock cycles after the clock edge that first samples the new pin level.
- R3: With `cap_mode` = 3'b011, each rising edge of `cap_pin` stores one capture, with the same two-cycle lag as R2. Falling edges store nothing.
- R4: With `cap_mode` = 3'b001, every rising edge and every falling edge of `cap_pin` stores one capture.
- R5: With `cap_mode` = 3'b100, only every 4th rising edge stores a capture; with 3'b101, only every 16th. The edge count restarts from zero whenever `cap_mode` changes value.
- R6: `tmr_sel` = 0 captures `tmr_a_val`; `tmr_sel` = 1 captures `tmr_b_val`.
- R7: `cap_mode` values 3'b000, 3'b110 and 3'b111 store no captures.
- R8: `irq_per` (0..3) sets the interrupt to fire once every `irq_per`+1 captures. `irq_flag` rises exactly two clock cycles after the clock edge that writes the completing capture. The capture count restarts after each interrupt and on any `cap_mode` change.
- R9: `irq_flag` stays at 1 until a cycle with `irq_clr` = 1.
- R10: The queue holds 4 captures. `fifo_rdata` shows the oldest capture while `fifo_nempty` = 1, and `fifo_pop` = 1 removes it.
- R11: A capture that arrives while 4 entries are held and no pop is made is discarded. It sets `fifo_ovf`, which stays 1 until reset. The interrupt count still advances for the discarded capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| tmr_a_val | input | 16 | Timer A count |
| tmr_b_val | input | 16 | Timer B count |
| cap_mode | input | 3 | Capture mode code |
| tmr_sel | input | 1 | Timer choice, 0 = A, 1 = B |
| irq_per | input | 2 | Captures per interrupt, minus one |
| irq_clr | input | 1 | Clears the interrupt flag |
| fifo_pop | input | 1 | Removes the oldest capture |
| fifo_rdata | output | 16 | Oldest capture in the queue |
| fifo_nempty | output | 1 | Queue holds at least one capture |
| fifo_ovf | output | 1 | Sticky: a capture was dropped |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench sweeps every mode code against both timer choices and every interrupt period.

- **Capture lag.** It predicts the exact captured timer value from the two-cycle lag. A design with one synchronizer stage too many or too few would show an off-by-one timestamp.
- **Prescaler restart.** It rewrites a prescaler mode partway through a count. A prescaler that does not restart would capture on the wrong edge.
- **Interrupt latency.** It times the flag cycle by cycle. A flag one cycle early or late, or a capture counter that is not cleared, would fire on the wrong capture.
- **Full queue.** It overfills the queue and drains it. A queue that overwrote old data, or a count that skipped dropped captures, would return the wrong values or miss the interrupt.

// File: rtl/icap_pkg.sv
// Shared mode codes for the input capture channel.
package icap_pkg;
    typedef enum logic [2:0] {
        CAPM_OFF   = 3'b000,
        CAPM_BOTH  = 3'b001,
        CAPM_FALL  = 3'b010,
        CAPM_RISE  = 3'b011,
        CAPM_DIV_A = 3'b100,
        CAPM_DIV_B = 3'b101
    } cap_mode_e;
endpackage

// File: rtl/icap_sync_edge.sv
// Brings the asynchronous pin into the clock domain (two flops) and
// registers one more stage for edge detection.
// Assumes: pin high and low times each span at least two clock periods.
module icap_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    // Synchronizer chain plus edge-detect history register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge strobes from the synchronized level and its delayed copy
    always_comb begin
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
    end
endmodule

// File: rtl/icap_event_gen.sv
// Decodes the capture mode and turns synchronized edges into capture
// events, including the rising-edge prescaler. A change of mode is
// flagged for one cycle. In that cycle the prescaler restarts and no
// event is issued.
// Assumes: DIV_LO < DIV_HI, and both are at least 2.
module icap_event_gen #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       rise,
    input  logic       fall,
    output logic       cap_evt,
    output logic       mode_chg
);
    import icap_pkg::*;

    localparam int PW = $clog2(DIV_HI);

    logic [2:0]    mode_q;
    logic [PW-1:0] pre_cnt;
    logic [PW-1:0] pre_last;
    logic          pre_mode;
    logic          pre_hit;
    cap_mode_e     m;

    // Remember the last mode to detect rewrites
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 3'b000;
        else        mode_q <= mode;
    end

    // Mode decode and prescaler terminal value
    always_comb begin
        m        = cap_mode_e'(mode);
        mode_chg = (mode != mode_q);
        pre_mode = (m == CAPM_DIV_A) || (m == CAPM_DIV_B);
        pre_last = (m == CAPM_DIV_A) ? PW'(DIV_LO - 1) : PW'(DIV_HI - 1);
        pre_hit  = pre_mode && rise && (pre_cnt == pre_last);
    end

    // Rising-edge prescaler: restarts on mode change or outside its modes
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg || !pre_mode) pre_cnt <= '0;
        else if (rise) pre_cnt <= pre_hit ? '0 : pre_cnt + 1'b1;
    end

    // Capture event selection per mode
    always_comb begin
        case (m)
            CAPM_BOTH:              cap_evt = rise | fall;
            CAPM_FALL:              cap_evt = fall;
            CAPM_RISE:              cap_evt = rise;
            CAPM_DIV_A, CAPM_DIV_B: cap_evt = pre_hit;
            default:                cap_evt = 1'b0;
        endcase
        if (mode_chg) cap_evt = 1'b0;
    end
endmodule

// File: rtl/icap_irq.sv
// Counts capture events and raises a sticky interrupt flag two cycles
// after the event that reaches the programmed count.
// Assumes: the period field may change only together with a mode change.
module icap_irq #(
    parameter int PER_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic             mode_chg,
    input  logic [PER_W-1:0] per,
    input  logic             clr,
    output logic             flag
);
    logic [PER_W-1:0] ev_cnt;
    logic             hit, dly1, dly2;

    // The event that completes the period
    always_comb hit = cap_evt && (ev_cnt == per);

    // Event counter: clears on completion or mode change
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg) ev_cnt <= '0;
        else if (hit)           ev_cnt <= '0;
        else if (cap_evt)       ev_cnt <= ev_cnt + 1'b1;
    end

    // Two-stage latency line; the flag is set as the second stage leaves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly1 <= 1'b0;
            dly2 <= 1'b0;
            flag <= 1'b0;
        end else begin
            dly1 <= hit;
            dly2 <= dly1;
            if (dly2)     flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/icap_fifo.sv
// Small show-ahead queue for capture values. A write into a full queue
// without a simultaneous pop is dropped and recorded in a sticky bit.
// Assumes: DEPTH >= 2.
module icap_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         nempty,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          full, do_rd, do_wr;

    // Step a pointer with wrap at the last entry
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept/pop qualification
    always_comb begin
        full    = (cnt == CW'(DEPTH));
        nempty  = (cnt != '0);
        do_rd   = rd_en && nempty;
        do_wr   = wr_en && (!full || do_rd);
        rd_data = mem[rptr];
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Pointers, occupancy and the sticky drop indicator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
        end else begin
            if (do_wr) wptr <= step(wptr);
            if (do_rd) rptr <= step(rptr);
            if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
            else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
            if (wr_en && !do_wr) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/ic_capture_channel.sv
// Input capture channel top.
// - Synchronizes the pin and qualifies edges by mode.
// - Snapshots the chosen timer into a queue on each capture event.
// - Raises a sticky, delayed interrupt every N captures.
// Assumes: the timer inputs are synchronous to clk.
module ic_capture_channel #(
    parameter int TMR_W  = 16,
    parameter int DEPTH  = 4,
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 16,
    parameter int PER_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [TMR_W-1:0] tmr_a_val,
    input  logic [TMR_W-1:0] tmr_b_val,
    input  logic [2:0]       cap_mode,
    input  logic             tmr_sel,
    input  logic [PER_W-1:0] irq_per,
    input  logic             irq_clr,
    input  logic             fifo_pop,
    output logic [TMR_W-1:0] fifo_rdata,
    output logic             fifo_nempty,
    output logic             fifo_ovf,
    output logic             irq_flag
);
    logic             pin_rise, pin_fall, cap_evt, mode_chg;
    logic [TMR_W-1:0] tmr_pick;

    // Time base choice
    always_comb tmr_pick = tmr_sel ? tmr_b_val : tmr_a_val;

    icap_sync_edge u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cap_pin),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    icap_event_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cap_mode),
        .rise     (pin_rise),
        .fall     (pin_fall),
        .cap_evt  (cap_evt),
        .mode_chg (mode_chg)
    );

    icap_fifo #(.W(TMR_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_evt),
        .wr_data (tmr_pick),
        .rd_en   (fifo_pop),
        .rd_data (fifo_rdata),
        .nempty  (fifo_nempty),
        .ovf     (fifo_ovf)
    );

    icap_irq #(.PER_W(PER_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_evt  (cap_evt),
        .mode_chg (mode_chg),
        .per      (irq_per),
        .clr      (irq_clr),
        .flag     (irq_flag)
    );
endmodule

// File: rtl/icap_checker.sv
// Protocol checks for the capture channel, bound to the top module.
module icap_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cap_mode,
    input logic       fifo_pop,
    input logic       irq_clr,
    input logic       cap_evt,
    input logic       fifo_nempty,
    input logic       fifo_ovf,
    input logic       irq_flag
);
    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(cap_evt, 3)); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf |=> fifo_ovf); // R11
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == 3'b000 || cap_mode == 3'b110 || cap_mode == 3'b111) |-> !cap_evt); // R7
    AST_EMPTY_BY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_nempty) |-> $past(fifo_pop)); // R10
    AST_FILLED_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> fifo_nempty); // R10
endmodule

bind ic_capture_channel icap_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_mode    (cap_mode),
    .fifo_pop    (fifo_pop),
    .irq_clr     (irq_clr),
    .cap_evt     (cap_evt),
    .fifo_nempty (fifo_nempty),
    .fifo_ovf    (fifo_ovf),
    .irq_flag    (irq_flag)
);

// File: tb/sim_ic_capture_channel.sv
`timescale 1ns/1ps
module sim_ic_capture_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] tcnt = 16'h0000;
    logic [15:0] tmr_a_val, tmr_b_val, fifo_rdata;
    logic [2:0]  cap_mode = 3'b000;
    logic        tmr_sel = 1'b0;
    logic [1:0]  irq_per = 2'd0;
    logic        irq_clr = 1'b0, fifo_pop = 1'b0;
    logic        fifo_nempty, fifo_ovf, irq_flag;
    int          n_chk = 0, n_err = 0;
    int          pcnt_m = 0, ecnt_m = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 16'd1;
    assign tmr_a_val = tcnt;
    assign tmr_b_val = tcnt ^ 16'hC3A5;

    ic_capture_channel u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin),
        .tmr_a_val(tmr_a_val), .tmr_b_val(tmr_b_val),
        .cap_mode(cap_mode), .tmr_sel(tmr_sel), .irq_per(irq_per),
        .irq_clr(irq_clr), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
        .fifo_nempty(fifo_nempty), .fifo_ovf(fifo_ovf), .irq_flag(irq_flag)
    );

    function automatic logic [15:0] tmr_of(input logic [15:0] v, input logic s);
        return s ? (v ^ 16'hC3A5) : v;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Mode rewrite through the disabled code; clears the model counters
    task automatic set_cfg(input logic [2:0] m, input logic s, input logic [1:0] p);
        cap_mode = 3'b000;
        cycles(2);
        cap_mode = m; tmr_sel = s; irq_per = p;
        cycles(2);
        pcnt_m = 0; ecnt_m = 0;
    endtask

    function automatic string mode_req(input logic [2:0] m);
        case (m)
            3'b001: return "R4";
            3'b010: return "R2";
            3'b011: return "R3";
            3'b100, 3'b101: return "R5";
            default: return "R7";
        endcase
    endfunction

    // Model decision for one pin toggle; updates prescale and irq counters
    task automatic model_edge(input logic rising, output logic evt, output logic irq);
        evt = 1'b0; irq = 1'b0;
        case (cap_mode)
            3'b001: evt = 1'b1;
            3'b010: evt = !rising;
            3'b011: evt = rising;
            3'b100, 3'b101: if (rising) begin
                pcnt_m++;
                if (pcnt_m == ((cap_mode == 3'b100) ? 4 : 16)) begin
                    evt = 1'b1; pcnt_m = 0;
                end
            end
            default: evt = 1'b0;
        endcase
        if (evt) begin
            if (ecnt_m == int'(irq_per)) begin irq = 1'b1; ecnt_m = 0; end
            else ecnt_m++;
        end
    endtask

    // One pin toggle, then check and drain the capture and the interrupt
    task automatic step_check();
        logic [15:0] v;
        logic evt, irq;
        v = tcnt;
        cap_pin = ~cap_pin;
        model_edge(cap_pin, evt, irq);
        cycles(6);
        chk(mode_req(cap_mode), 16'(fifo_nempty), 16'(evt));
        if (evt) begin
            chk("R6", fifo_rdata, tmr_of(v + 16'd2, tmr_sel));
            fifo_pop = 1'b1; cycles(1); fifo_pop = 1'b0;
            chk("R10", 16'(fifo_nempty), 16'd0);
        end
        chk("R8", 16'(irq_flag), 16'(irq));
        if (irq_flag) begin
            irq_clr = 1'b1; cycles(1); irq_clr = 1'b0;
            chk("R9", 16'(irq_flag), 16'd0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [15:0] exp_q [4];
        logic [2:0]  modes [8];
        modes = '{3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b000, 3'b110, 3'b111};
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        chk("R1", 16'(fifo_nempty), 16'd0);
        chk("R1", 16'(irq_flag), 16'd0);
        chk("R1", 16'(fifo_ovf), 16'd0);

        // R8 exact latency, cycle by cycle
        set_cfg(3'b011, 1'b0, 2'd0);
        cap_pin = 1'b1; pcnt_m = 0;
        cycles(2);
        chk("R3", 16'(fifo_nempty), 16'd0);
        cycles(1);
        chk("R3", 16'(fifo_nempty), 16'd1);
        chk("R8", 16'(irq_flag), 16'd0);
        cycles(1);
        chk("R8", 16'(irq_flag), 16'd0);
        cycles(1);
        chk("R8", 16'(irq_flag), 16'd1);
        cycles(3);
        chk("R9", 16'(irq_flag), 16'd1);
        irq_clr = 1'b1; cycles(1); irq_clr = 1'b0;
        chk("R9", 16'(irq_flag), 16'd0);
        fifo_pop = 1'b1; cycles(1); fifo_pop = 1'b0;
        cap_pin = 1'b0; cycles(6);

        // Sweep: every mode code, both timers, every irq period
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 8; k++) begin
                set_cfg(modes[k], s[0], 2'(k + s));
                for (int t = 0; t < 36; t++) step_check();
            end
        end

        // R5 prescaler restart on a mode rewrite mid-count
        set_cfg(3'b100, 1'b0, 2'd3);
        for (int t = 0; t < 6; t++) step_check();
        set_cfg(3'b100, 1'b0, 2'd3);
        for (int t = 0; t < 8; t++) step_check();

        // R11 overflow: 5 rising captures, no pops, period 4
        set_cfg(3'b011, 1'b1, 2'd3);
        for (int t = 0; t < 10; t++) begin
            if (!cap_pin && t < 8) exp_q[t/2] = tmr_of(tcnt + 16'd2, 1'b1);
            cap_pin = ~cap_pin;
            cycles(6);
        end
        chk("R11", 16'(fifo_ovf), 16'd1);
        chk("R11", 16'(irq_flag), 16'd1);
        for (int i = 0; i < 4; i++) begin
            chk("R10", 16'(fifo_nempty), 16'd1);
            chk("R11", fifo_rdata, exp_q[i]);
            fifo_pop = 1'b1; cycles(1); fifo_pop = 1'b0;
        end
        chk("R10", 16'(fifo_nempty), 16'd0);
        cycles(3);
        chk("R11", 16'(fifo_ovf), 16'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule